// File: doc/BRIEF.md
# Operand Register File with Indirect Pointers

This block holds the thirty-two 8-bit working registers of a small 8-bit processor core. Two combinational read ports supply the source and destination operands, and the same index on the first port also yields a 16-bit value from the even/odd pair that contains it. One write port per clock stores either a single byte or a full 16-bit value into an even/odd pair.

The same storage appears at the bottom of the data address space. A data-bus master that reads or writes an address below 32 reaches the register of the same number instead of memory. The top six registers double as three 16-bit address pointers. A pointer port selects one of them and produces an effective address. It can add a small unsigned displacement, or it can step the pointer up after use or down before use, and the stepped value is written back on the clock edge.

Top module: `regfile_ptr`

## Requirements
- R1: After reset every register reads zero.
- R2: Both read ports return, in the same cycle and without a clock edge, the registers named by `rd_a_idx` and `rd_b_idx`.
- R3: `rd_pair_data` returns the register at `rd_a_idx` with bit 0 cleared as bits 7:0, and the next register up as bits 15:8.
- R4: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored into register `wr_idx` at the clock edge, and no other register changes.
- R5: With `wr_en`=1 and `wr_wide`=1, `wr_data[7:0]` goes to the even register of the pair that holds `wr_idx`, and `wr_data[15:8]` goes to the odd register. Bit 0 of `wr_idx` is ignored.
- R6: A bus address below 32 sets `bus_hit`=1, and `bus_rdata` then holds register `bus_addr`. Any other address gives `bus_hit`=0 and `bus_rdata`=0.
- R7: With `bus_we`=1, `bus_wdata` is stored into register `bus_addr` when the address is below 32. A bus write to any higher address changes no register.
- R8: `ptr_sel` picks the pointer: 0 selects registers 26/27, 1 selects 28/29, and 2 or 3 selects 30/31, with the lower register as the low byte. With `ptr_op` 0 or 3, `ptr_addr` is the pointer plus the zero-extended `ptr_disp`, and the pointer does not change even when `ptr_en`=1.
- R9: With `ptr_op`=1 (post-increment), `ptr_addr` is the old pointer value. If `ptr_en`=1, the pointer becomes that value plus 1, modulo 2^16, at the edge.
- R10: With `ptr_op`=2 (pre-decrement), `ptr_addr` is the pointer minus 1, modulo 2^16. If `ptr_en`=1, that value is written back at the edge.
- R11: When writes collide on one register in one cycle, the write port wins over a pointer update, and a pointer update wins over a bus write. Writes to different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 5 | First operand index |
| rd_a_data | output | 8 | First operand value |
| rd_b_idx | input | 5 | Second operand index |
| rd_b_data | output | 8 | Second operand value |
| rd_pair_data | output | 16 | Pair value containing rd_a_idx |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_idx | input | 5 | Write target index |
| wr_data | input | 16 | Write value (byte write uses bits 7:0) |
| bus_addr | input | 16 | Data-bus address |
| bus_we | input | 1 | Data-bus write strobe |
| bus_wdata | input | 8 | Data-bus write value |
| bus_rdata | output | 8 | Data-bus read value |
| bus_hit | output | 1 | Address falls in the register window |
| ptr_sel | input | 2 | Pointer select |
| ptr_op | input | 2 | 0/3 displacement, 1 post-increment, 2 pre-decrement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_en | input | 1 | Commit the pointer step |
| ptr_addr | output | 16 | Effective address |

## Verification
Three write sources can reach one register in the same cycle: the write port, a committed pointer step, and a bus write into the aliased window. The bench makes them collide on purpose. It issues a byte write and a bus write to the same register, a pointer step and a bus write to the low byte of that pointer, and a wide write over the pair a pointer is stepping. It then reads every register back through both operand ports and compares each value against a model that applies the stated priority. It also issues byte and bus writes to different registers in one cycle, and confirms that both land.

// File: rtl/regfile_ptr.sv
module regfile_ptr #(
  parameter int NREG  = 32,
  parameter int DW    = 8,
  parameter int AW    = 16,
  parameter int DISPW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  output logic [2*DW-1:0]   rd_pair_data,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [2*DW-1:0]   wr_data,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_hit,
  input  logic [1:0]        ptr_sel,
  input  logic [1:0]        ptr_op,
  input  logic [DISPW-1:0]  ptr_disp,
  input  logic              ptr_en,
  output logic [2*DW-1:0]   ptr_addr
);
  localparam int IW    = $clog2(NREG);
  localparam int PW    = 2 * DW;
  localparam int PBASE = NREG - 6;

  logic [DW-1:0] regs [NREG];

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  logic [IW-1:0] pair_lo;
  assign pair_lo      = {rd_a_idx[IW-1:1], 1'b0};
  assign rd_pair_data = {regs[pair_lo | IW'(1)], regs[pair_lo]};

  assign bus_hit   = (bus_addr < AW'(NREG));
  assign bus_rdata = bus_hit ? regs[bus_addr[IW-1:0]] : '0;

  logic [1:0]    psel;
  logic [IW-1:0] p_lo;
  logic [PW-1:0] p_cur, p_inc, p_dec, p_new;
  logic          p_upd;

  assign psel  = (ptr_sel > 2'd2) ? 2'd2 : ptr_sel;
  assign p_lo  = IW'(PBASE) + IW'({psel, 1'b0});
  assign p_cur = {regs[p_lo | IW'(1)], regs[p_lo]};
  assign p_inc = p_cur + PW'(1);
  assign p_dec = p_cur - PW'(1);
  assign p_upd = ptr_en && (ptr_op == 2'd1 || ptr_op == 2'd2);
  assign p_new = (ptr_op == 2'd1) ? p_inc : p_dec;

  always_comb begin
    case (ptr_op)
      2'd1:    ptr_addr = p_cur;
      2'd2:    ptr_addr = p_dec;
      default: ptr_addr = p_cur + PW'(ptr_disp);
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IW-1:0] GI = IW'(g);
    logic          core_hit, ptr_hit, bus_w;
    logic [DW-1:0] core_val, ptr_val;

    assign core_hit = wr_en && (wr_wide ? (wr_idx[IW-1:1] == GI[IW-1:1])
                                        : (wr_idx == GI));
    assign core_val = (wr_wide && GI[0]) ? wr_data[PW-1:DW] : wr_data[DW-1:0];
    assign ptr_hit  = p_upd && (p_lo[IW-1:1] == GI[IW-1:1]);
    assign ptr_val  = GI[0] ? p_new[PW-1:DW] : p_new[DW-1:0];
    assign bus_w    = bus_we && bus_hit && (bus_addr[IW-1:0] == GI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs[g] <= '0;
      else if (core_hit) regs[g] <= core_val;
      else if (ptr_hit)  regs[g] <= ptr_val;
      else if (bus_w)    regs[g] <= bus_wdata;
    end
  end
endmodule

module regfile_ptr_chk #(
  parameter int NREG  = 32,
  parameter int DW    = 8,
  parameter int AW    = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DW-1:0]           regs [NREG],
  input logic [$clog2(NREG)-1:0] rd_a_idx,
  input logic [DW-1:0]           rd_a_data,
  input logic                    wr_en,
  input logic                    wr_wide,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [2*DW-1:0]         wr_data,
  input logic [AW-1:0]           bus_addr,
  input logic                    bus_we,
  input logic [DW-1:0]           bus_rdata,
  input logic                    bus_hit,
  input logic [1:0]              ptr_sel,
  input logic [1:0]              ptr_op,
  input logic                    ptr_en,
  input logic [2*DW-1:0]         ptr_addr
);
  localparam int IW = $clog2(NREG);

  function automatic logic [IW-1:0] pidx(input logic [1:0] s);
    return (s >= 2'd2) ? IW'(NREG - 2) : IW'(NREG - 6 + 2 * int'(s));
  endfunction

  a_r4_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |=> regs[$past(wr_idx)] == $past(wr_data[DW-1:0]));

  a_r5_wide_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wide) |=>
      (regs[{$past(wr_idx[IW-1:1]), 1'b0}] == $past(wr_data[DW-1:0])) &&
      (regs[{$past(wr_idx[IW-1:1]), 1'b1}] == $past(wr_data[2*DW-1:DW])));

  a_r6_bus_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && bus_addr[IW-1:0] == rd_a_idx) |-> bus_rdata == rd_a_data);

  a_r9_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_op == 2'd1 && !wr_en) |=>
      {regs[pidx($past(ptr_sel)) + IW'(1)], regs[pidx($past(ptr_sel))]}
        == $past(ptr_addr) + 16'd1);

  a_r10_pre_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_op == 2'd2 && !wr_en) |=>
      {regs[pidx($past(ptr_sel)) + IW'(1)], regs[pidx($past(ptr_sel))]}
        == $past(ptr_addr));

  a_r11_core_over_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && bus_we && bus_addr == AW'(wr_idx)) |=>
      regs[$past(wr_idx)] == $past(wr_data[DW-1:0]));
endmodule

bind regfile_ptr regfile_ptr_chk #(.NREG(NREG), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .regs(regs),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
  .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_en(ptr_en), .ptr_addr(ptr_addr)
);

// File: tb/regfile_ptr_tb_top.sv
module regfile_ptr_tb_top;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, bus_wdata, bus_rdata;
  logic [15:0] rd_pair_data, wr_data, bus_addr, ptr_addr;
  logic        wr_en, wr_wide, bus_we, bus_hit, ptr_en;
  logic [1:0]  ptr_sel, ptr_op;
  logic [5:0]  ptr_disp;

  regfile_ptr dut_i (.*);

  int checks = 0, errors = 0;
  logic [7:0] model [32];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
    bus_we = 0; bus_addr = 16'hFFFF; bus_wdata = 0;
    ptr_en = 0; ptr_sel = 0; ptr_op = 0; ptr_disp = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic verify_all(string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); #1;
      check(req, {8'h0, rd_a_data}, {8'h0, model[i]});
      check(req, {8'h0, rd_b_data}, {8'h0, model[31 - i]});
    end
  endtask

  function automatic int pbase(int s);
    return (s >= 2) ? 30 : 26 + 2 * s;
  endfunction

  function automatic logic [15:0] mptr(int s);
    return {model[pbase(s) + 1], model[pbase(s)]};
  endfunction

  task automatic set_ptr(int s, logic [15:0] v);
    wr_en = 1; wr_wide = 1; wr_idx = 5'(pbase(s)); wr_data = v;
    model[pbase(s)] = v[7:0]; model[pbase(s) + 1] = v[15:8];
    tick();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(); rd_a_idx = 0; rd_b_idx = 0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    verify_all("R1");

    // R7 bus writes into the window
    for (int i = 0; i < 32; i++) begin
      bus_we = 1; bus_addr = 16'(i); bus_wdata = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
      tick();
    end
    verify_all("R7/R2");
    // R6 bus reads in and out of window
    for (int i = 0; i < 32; i++) begin
      bus_addr = 16'(i); #1;
      check("R6 hit", {15'h0, bus_hit}, 16'h1);
      check("R6 data", {8'h0, bus_rdata}, {8'h0, model[i]});
    end
    foreach (bus_addr_list[k]) ;
    bus_addr = 16'h0020; #1;
    check("R6 miss", {15'h0, bus_hit}, 16'h0);
    check("R6 miss data", {8'h0, bus_rdata}, 16'h0);
    bus_addr = 16'h0105; #1;
    check("R6 miss", {15'h0, bus_hit}, 16'h0);
    check("R6 miss data", {8'h0, bus_rdata}, 16'h0);
    // R7 bus writes above window ignored
    for (int i = 0; i < 32; i++) begin
      bus_we = 1; bus_addr = 16'h0020 | 16'(i); bus_wdata = 8'hEE;
      tick();
    end
    verify_all("R7 out-of-range");

    // R4 byte writes
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = {8'hCC, 8'(i ^ 8'hA5)};
      model[i] = 8'(i ^ 8'hA5);
      tick();
    end
    verify_all("R4");
    // R3 pair reads with odd and even index
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); #1;
      check("R3", rd_pair_data, {model[i | 1], model[i & 30]});
    end

    // R5 wide writes using odd index
    for (int p = 0; p < 16; p++) begin
      wr_en = 1; wr_wide = 1; wr_idx = 5'(2 * p + 1);
      wr_data = {8'(p * 17), 8'(~(p * 3))};
      model[2 * p] = 8'(~(p * 3)); model[2 * p + 1] = 8'(p * 17);
      tick();
    end
    verify_all("R5");

    // R8 displacement, no update even with ptr_en
    for (int s = 0; s < 4; s++) begin
      set_ptr(s, 16'h12F0 + 16'(s));
      for (int op = 0; op < 4; op += 3) begin
        ptr_sel = 2'(s); ptr_op = 2'(op); ptr_disp = 6'd63; ptr_en = 1; #1;
        check("R8 disp", ptr_addr, mptr(s) + 16'd63);
        tick();
        ptr_sel = 2'(s); #1;
        check("R8 no change", ptr_addr, mptr(s));
      end
    end

    // R9 / R10 with wrap-around
    for (int s = 0; s < 4; s++) begin
      set_ptr(s, 16'hFFFF);
      ptr_sel = 2'(s); ptr_op = 2'd1; ptr_en = 1; #1;
      check("R9 addr", ptr_addr, 16'hFFFF);
      tick();
      model[pbase(s)] = 8'h00; model[pbase(s) + 1] = 8'h00;
      verify_all("R9 wrap");
      ptr_sel = 2'(s); ptr_op = 2'd2; ptr_en = 1; #1;
      check("R10 addr", ptr_addr, 16'hFFFF);
      tick();
      model[pbase(s)] = 8'hFF; model[pbase(s) + 1] = 8'hFF;
      verify_all("R10 wrap");
      set_ptr(s, 16'h0100);
      ptr_sel = 2'(s); ptr_op = 2'd2; ptr_en = 0; #1;
      check("R10 no commit addr", ptr_addr, 16'h00FF);
      tick();
      ptr_sel = 2'(s); ptr_op = 2'd1; #1;
      check("R9 no commit", ptr_addr, 16'h0100);
      ptr_en = 1; tick();
      ptr_sel = 2'(s); #1;
      check("R9 step", ptr_addr, 16'h0101);
      model[pbase(s)] = 8'h01;
    end
    verify_all("R9/R10");

    // R11 collisions
    wr_en = 1; wr_idx = 5'd9; wr_data = 16'h0011;
    bus_we = 1; bus_addr = 16'd9; bus_wdata = 8'h22;
    model[9] = 8'h11; tick();
    verify_all("R11 core over bus");
    set_ptr(0, 16'h20FF);
    ptr_sel = 0; ptr_op = 2'd1; ptr_en = 1;
    bus_we = 1; bus_addr = 16'd26; bus_wdata = 8'h55;
    model[26] = 8'h00; model[27] = 8'h21; tick();
    verify_all("R11 pointer over bus");
    ptr_sel = 2'd1; ptr_op = 2'd2; ptr_en = 1;
    wr_en = 1; wr_wide = 1; wr_idx = 5'd28; wr_data = 16'hBEEF;
    model[28] = 8'hEF; model[29] = 8'hBE; tick();
    verify_all("R11 core over pointer");
    wr_en = 1; wr_idx = 5'd3; wr_data = 16'h0077;
    bus_we = 1; bus_addr = 16'd4; bus_wdata = 8'h88;
    model[3] = 8'h77; model[4] = 8'h88; tick();
    verify_all("R11 disjoint");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int bus_addr_list [1];
endmodule